// File: doc/BRIEF.md
# Link Width Degradation Controller

This block is the link-layer controller for one point-to-point serial link of twenty data lanes. On the transmit side it protects each flit with an 8-bit CRC and keeps the last eight unacknowledged flits in a replay buffer. It resends them in order when the far end asks for a retry, and again after every retrain. On the receive side it checks the CRC of each incoming flit. A clean flit is delivered. A corrupted flit is dropped and a retry request is raised toward the sender.

The block also protects the link against persistent faults. The twenty lanes form four groups of five, and each group has its own error count. When an active group's count reaches a programmable threshold, or when a run of consecutive CRC failures shows that retry is not helping, the link retrains one step narrower: from twenty lanes to ten, then from ten to five. The surviving lanes avoid the faulty group. If the forwarded clock fails, the clock is moved onto one of the two dual-use lanes in the middle of the link, lane 9 or lane 10, and that lane stops carrying data. Training is modelled as a fixed-length quiet period. The width never increases again until reset.

Top module: `link_width_ctrl`

## Requirements
- R1: Each transmitted flit is `{data, crc}`, with the CRC in the low 8 bits. The CRC uses polynomial x^8+x^2+x+1 (0x07) with an initial value of 0, over the data taken MSB first. A flit accepted on `txValid && txReady` appears on `linkTxFlit` with `linkTxValid` one cycle later.
- R2: A received flit with a matching CRC shows on `rxOutData` with `rxOutValid` one cycle later. A flit with a mismatching CRC is not delivered; `retryOut` pulses one cycle later instead. Single-bit errors, three-bit errors and bursts of up to 8 bits are all caught.
- R3: The replay buffer holds 8 unacknowledged flits. `txReady` is low while 8 are held. Each `ackIn` pulse frees the oldest one.
- R4: A `retryIn` pulse while the link is up resends every unacknowledged flit, oldest first, one per cycle. The first one appears two cycles after the pulse. `txReady` stays low while the replay runs.
- R5: Each active lane group counts the cycles in which any of its lanes flags `laneErr`. When a count reaches a nonzero `errThreshold`, the width steps down. A threshold of 0 turns this off.
- R6: Going from full width to half width keeps the half (lanes 0-9 or lanes 10-19) that does not hold the tripping group. Going from half width to quarter width keeps the lower group of the active half, unless that group tripped.
- R7: Four consecutive received flits with a CRC error step the width down, choosing the lower half or the lower group. A clean flit resets the run.
- R8: `widthMode` is 0 for full, 1 for half and 2 for quarter. It never increases. Quarter width is final. `laneMask` shows the active lanes (group g is lanes 5g to 5g+4).
- R9: Every width or clock change drops `linkUp` for exactly 8 cycles and clears the error counts. When `linkUp` returns, all unacknowledged flits are resent in order.
- R10: On `clkFail`, `clkLaneSel` becomes 1 (lane 9), or 2 (lane 10) if lane 9 still carries data; 0 means the dedicated clock lane. If the link was at full width it first drops to lanes 0-9. The choice is kept until reset.
- R11: `laneErr` on lanes that are not active has no effect.
- R12: Reset gives full width, an all-ones `laneMask`, the dedicated clock lane and `linkUp` low. The link comes up after the training period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txValid | input | 1 | Transmit data offered |
| txData | input | 32 | Transmit payload |
| txReady | output | 1 | Transmit payload accepted this cycle |
| linkTxValid | output | 1 | Flit on the link this cycle |
| linkTxFlit | output | 40 | Flit sent: data and CRC |
| ackIn | input | 1 | Far end acknowledges the oldest held flit |
| retryIn | input | 1 | Far end requests retransmission |
| rxValid | input | 1 | Received flit present |
| rxFlit | input | 40 | Received flit: data and CRC |
| rxOutValid | output | 1 | Clean received payload present |
| rxOutData | output | 32 | Received payload |
| retryOut | output | 1 | Retry request for a corrupted flit |
| laneErr | input | 20 | Per-lane error flags |
| clkFail | input | 1 | Forwarded clock failure |
| errThreshold | input | 8 | Lane group error count that triggers narrowing |
| widthMode | output | 2 | Current width: 0 full, 1 half, 2 quarter |
| laneMask | output | 20 | Lanes carrying data |
| clkLaneSel | output | 2 | Clock lane: 0 dedicated, 1 lane 9, 2 lane 10 |
| linkUp | output | 1 | Link trained and carrying traffic |

## Verification
A corrupted group counter or threshold compare shows up as a change of `widthMode` and `laneMask` one cycle early or one cycle late, or as a wrong half or group being kept. The bench therefore samples the exact cycle after the tripping error. Wrong replay pointers show up as flits out of order or missing in the stream that follows a retry or a retrain. That stream starts two cycles after the trigger, so these faults are visible within a few cycles. A wrong training counter changes the number of cycles with `linkUp` low, which the bench counts.

// File: rtl/ldc_pkg.sv
package ldc_pkg;

  typedef enum logic [1:0] {
    WIDTH_FULL    = 2'd0,
    WIDTH_HALF    = 2'd1,
    WIDTH_QUARTER = 2'd2
  } width_e;

  typedef enum logic [1:0] {
    CLK_DEDICATED = 2'd0,
    CLK_ALT_LO    = 2'd1,
    CLK_ALT_HI    = 2'd2
  } clksel_e;

  // Strobes from the width controller to the flit datapath.
  typedef struct packed {
    logic linkUp;
    logic startReplay;
  } ctrl_strobe_t;

endpackage

// File: rtl/ldc_ctrl.sv
module ldc_ctrl
  import ldc_pkg::*;
#(
  parameter int LANES        = 20,
  parameter int TRAIN_CYCLES = 8,
  parameter int RETRY_LIMIT  = 4,
  parameter int ERR_W        = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LANES-1:0] laneErr,
  input  logic [ERR_W-1:0] errThreshold,
  input  logic             clkFail,
  input  logic             crcBad,
  input  logic             crcGood,
  output ctrl_strobe_t     strobe,
  output logic [1:0]       widthMode,
  output logic [LANES-1:0] laneMask,
  output logic [1:0]       clkLaneSel
);

  localparam int NGROUP      = 4;
  localparam int GROUP_W     = LANES / NGROUP;
  localparam int TRAIN_W     = $clog2(TRAIN_CYCLES + 1);
  localparam int RUN_W       = $clog2(RETRY_LIMIT + 1);
  localparam int CLK_LANE_A  = LANES / 2 - 1;
  localparam logic [1:0] CLK_A_GROUP = 2'(CLK_LANE_A / GROUP_W);
  localparam logic CLK_A_UPPER = (CLK_LANE_A / GROUP_W) >= (NGROUP / 2);

  width_e             widthQ, nWidth;
  logic               halfUpperQ, nHalf;
  logic [1:0]         quarterGroupQ, nQuarter;
  clksel_e            clkSelQ, nClk;
  logic               clkFailedQ;
  logic [TRAIN_W-1:0] trainCntQ;
  logic [RUN_W-1:0]   badRunQ;
  logic               linkUp;
  logic               retrain;
  logic [NGROUP-1:0]  groupActive;
  logic [NGROUP-1:0]  laneTrip;
  logic               laneTripAny;
  logic [1:0]         faultGroup;
  logic               crcTrip;
  logic               degradeReq;
  logic               clkReq;
  logic               laneABusy;

  assign linkUp = (trainCntQ == '0);

  for (genvar g = 0; g < NGROUP; g++) begin : g_group
    localparam logic       IS_UPPER = (g >= NGROUP / 2);
    localparam logic [1:0] GID      = 2'(g);
    logic [ERR_W-1:0] cntQ;
    logic             hit;

    always_comb begin
      unique case (widthQ)
        WIDTH_FULL:    groupActive[g] = 1'b1;
        WIDTH_HALF:    groupActive[g] = (halfUpperQ == IS_UPPER);
        WIDTH_QUARTER: groupActive[g] = (quarterGroupQ == GID);
        default:       groupActive[g] = 1'b0;
      endcase
    end

    assign laneMask[g*GROUP_W +: GROUP_W] = {GROUP_W{groupActive[g]}};
    assign hit = (|laneErr[g*GROUP_W +: GROUP_W]) && groupActive[g] && linkUp;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                  cntQ <= '0;
      else if (retrain)           cntQ <= '0;
      else if (hit && cntQ != '1) cntQ <= cntQ + 1'b1;
    end

    assign laneTrip[g] = (errThreshold != '0) && (cntQ >= errThreshold)
                         && groupActive[g] && linkUp;
  end

  assign laneTripAny = |laneTrip;

  always_comb begin
    faultGroup = '0;
    for (int i = NGROUP - 1; i >= 0; i--) begin
      if (laneTrip[i]) faultGroup = 2'(i);
    end
  end

  assign crcTrip    = (badRunQ >= RUN_W'(RETRY_LIMIT)) && linkUp;
  assign degradeReq = (laneTripAny || crcTrip) && (widthQ != WIDTH_QUARTER);
  assign clkReq     = clkFail && !clkFailedQ;

  always_comb begin
    nWidth    = widthQ;
    nHalf     = halfUpperQ;
    nQuarter  = quarterGroupQ;
    nClk      = clkSelQ;
    retrain   = 1'b0;
    laneABusy = 1'b0;
    if (clkReq) begin
      retrain = 1'b1;
      if (widthQ == WIDTH_FULL) begin
        nWidth = WIDTH_HALF;
        nHalf  = 1'b0;
      end
      laneABusy = (nWidth == WIDTH_HALF && nHalf == CLK_A_UPPER) ||
                  (nWidth == WIDTH_QUARTER && nQuarter == CLK_A_GROUP);
      nClk = laneABusy ? CLK_ALT_HI : CLK_ALT_LO;
    end else if (degradeReq) begin
      retrain = 1'b1;
      if (widthQ == WIDTH_FULL) begin
        nWidth = WIDTH_HALF;
        nHalf  = laneTripAny ? (faultGroup < 2'd2) : 1'b0;
      end else begin
        nWidth   = WIDTH_QUARTER;
        nQuarter = {halfUpperQ, laneTripAny && (faultGroup == {halfUpperQ, 1'b0})};
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      widthQ        <= WIDTH_FULL;
      halfUpperQ    <= 1'b0;
      quarterGroupQ <= '0;
      clkSelQ       <= CLK_DEDICATED;
      clkFailedQ    <= 1'b0;
      trainCntQ     <= TRAIN_W'(TRAIN_CYCLES);
    end else begin
      widthQ        <= nWidth;
      halfUpperQ    <= nHalf;
      quarterGroupQ <= nQuarter;
      clkSelQ       <= nClk;
      if (clkReq) clkFailedQ <= 1'b1;
      if (retrain)            trainCntQ <= TRAIN_W'(TRAIN_CYCLES);
      else if (!linkUp)       trainCntQ <= trainCntQ - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                    badRunQ <= '0;
    else if (retrain)                             badRunQ <= '0;
    else if (crcBad && badRunQ != RUN_W'(RETRY_LIMIT)) badRunQ <= badRunQ + 1'b1;
    else if (crcGood)                             badRunQ <= '0;
  end

  assign strobe.linkUp      = linkUp;
  assign strobe.startReplay = (trainCntQ == TRAIN_W'(1));
  assign widthMode          = widthQ;
  assign clkLaneSel         = clkSelQ;

endmodule

// File: rtl/ldc_datapath.sv
module ldc_datapath
  import ldc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  parameter int CRC_W  = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrl_strobe_t            strobe,
  input  logic                    txValid,
  input  logic [DATA_W-1:0]       txData,
  output logic                    txReady,
  output logic                    linkTxValid,
  output logic [DATA_W+CRC_W-1:0] linkTxFlit,
  input  logic                    ackIn,
  input  logic                    retryIn,
  input  logic                    rxValid,
  input  logic [DATA_W+CRC_W-1:0] rxFlit,
  output logic                    rxOutValid,
  output logic [DATA_W-1:0]       rxOutData,
  output logic                    retryOut,
  output logic                    crcBad,
  output logic                    crcGood
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CRC_W-1:0] POLY = CRC_W'(8'h07);

  function automatic logic [CRC_W-1:0] crcOf(input logic [DATA_W-1:0] d);
    logic [CRC_W-1:0] c;
    logic             fb;
    c = '0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      fb = c[CRC_W-1] ^ d[i];
      c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
    return c;
  endfunction

  logic [DATA_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  headQ, tailQ, rptrQ;
  logic [CNT_W-1:0]  countQ, rleftQ;
  logic              replayingQ;
  logic              txFire, ackPop, replayKick, rxCheck, rxMatch;
  logic [DATA_W-1:0] rxPayload;

  assign txReady = strobe.linkUp && !replayingQ && !retryIn && !strobe.startReplay
                   && (countQ != CNT_W'(DEPTH));
  assign txFire     = txValid && txReady;
  assign ackPop     = ackIn && (countQ != '0);
  assign replayKick = (retryIn && strobe.linkUp) || strobe.startReplay;

  always_ff @(posedge clk) begin
    if (txFire) store[tailQ] <= txData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headQ  <= '0;
      tailQ  <= '0;
      countQ <= '0;
    end else begin
      if (txFire) tailQ <= tailQ + 1'b1;
      if (ackPop) headQ <= headQ + 1'b1;
      countQ <= countQ + CNT_W'(txFire) - CNT_W'(ackPop);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      replayingQ  <= 1'b0;
      rptrQ       <= '0;
      rleftQ      <= '0;
      linkTxValid <= 1'b0;
      linkTxFlit  <= '0;
    end else if (replayKick && countQ != '0) begin
      replayingQ  <= 1'b1;
      rptrQ       <= headQ;
      rleftQ      <= countQ;
      linkTxValid <= 1'b0;
    end else if (replayingQ && strobe.linkUp) begin
      linkTxValid <= 1'b1;
      linkTxFlit  <= {store[rptrQ], crcOf(store[rptrQ])};
      rptrQ       <= rptrQ + 1'b1;
      rleftQ      <= rleftQ - 1'b1;
      if (rleftQ == CNT_W'(1)) replayingQ <= 1'b0;
    end else if (txFire) begin
      linkTxValid <= 1'b1;
      linkTxFlit  <= {txData, crcOf(txData)};
    end else begin
      linkTxValid <= 1'b0;
    end
  end

  assign rxPayload = rxFlit[DATA_W+CRC_W-1:CRC_W];
  assign rxCheck   = rxValid && strobe.linkUp;
  assign rxMatch   = (crcOf(rxPayload) == rxFlit[CRC_W-1:0]);
  assign crcBad    = rxCheck && !rxMatch;
  assign crcGood   = rxCheck && rxMatch;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxOutValid <= 1'b0;
      rxOutData  <= '0;
      retryOut   <= 1'b0;
    end else begin
      rxOutValid <= crcGood;
      retryOut   <= crcBad;
      if (crcGood) rxOutData <= rxPayload;
    end
  end

endmodule

// File: rtl/link_width_ctrl.sv
module link_width_ctrl
  import ldc_pkg::*;
#(
  parameter int LANES        = 20,
  parameter int DATA_W       = 32,
  parameter int DEPTH        = 8,
  parameter int TRAIN_CYCLES = 8,
  parameter int RETRY_LIMIT  = 4,
  parameter int ERR_W        = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                txValid,
  input  logic [DATA_W-1:0]   txData,
  output logic                txReady,
  output logic                linkTxValid,
  output logic [DATA_W+7:0]   linkTxFlit,
  input  logic                ackIn,
  input  logic                retryIn,
  input  logic                rxValid,
  input  logic [DATA_W+7:0]   rxFlit,
  output logic                rxOutValid,
  output logic [DATA_W-1:0]   rxOutData,
  output logic                retryOut,
  input  logic [LANES-1:0]    laneErr,
  input  logic                clkFail,
  input  logic [ERR_W-1:0]    errThreshold,
  output logic [1:0]          widthMode,
  output logic [LANES-1:0]    laneMask,
  output logic [1:0]          clkLaneSel,
  output logic                linkUp
);

  ctrl_strobe_t strobe;
  logic         crcBad, crcGood;

  ldc_ctrl #(
    .LANES(LANES), .TRAIN_CYCLES(TRAIN_CYCLES),
    .RETRY_LIMIT(RETRY_LIMIT), .ERR_W(ERR_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .laneErr(laneErr), .errThreshold(errThreshold),
    .clkFail(clkFail), .crcBad(crcBad), .crcGood(crcGood), .strobe(strobe),
    .widthMode(widthMode), .laneMask(laneMask), .clkLaneSel(clkLaneSel)
  );

  ldc_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CRC_W(8)) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .txValid(txValid), .txData(txData), .txReady(txReady),
    .linkTxValid(linkTxValid), .linkTxFlit(linkTxFlit),
    .ackIn(ackIn), .retryIn(retryIn),
    .rxValid(rxValid), .rxFlit(rxFlit),
    .rxOutValid(rxOutValid), .rxOutData(rxOutData), .retryOut(retryOut),
    .crcBad(crcBad), .crcGood(crcGood)
  );

  assign linkUp = strobe.linkUp;

endmodule

// File: rtl/link_width_ctrl_checker.sv
module link_width_ctrl_checker #(
  parameter int LANES = 20
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       widthMode,
  input logic [LANES-1:0] laneMask,
  input logic [1:0]       clkLaneSel,
  input logic             linkUp,
  input logic             txReady,
  input logic             rxValid,
  input logic             rxOutValid,
  input logic             retryOut
);

  localparam int LANE_A = LANES / 2 - 1;
  localparam int LANE_B = LANES / 2;

  assert_width_monotonic_R8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (widthMode >= $past(widthMode)));

  assert_mask_size_R8: assert property (@(posedge clk) disable iff (!rstN)
    $countones(laneMask) == (LANES >> widthMode));

  assert_clk_lane_a_free_R10: assert property (@(posedge clk) disable iff (!rstN)
    (clkLaneSel == 2'd1) |-> !laneMask[LANE_A]);

  assert_clk_lane_b_free_R10: assert property (@(posedge clk) disable iff (!rstN)
    (clkLaneSel == 2'd2) |-> !laneMask[LANE_B]);

  assert_clk_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    (clkLaneSel != 2'd0) |=> (clkLaneSel == $past(clkLaneSel)));

  assert_ready_needs_link_R9: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> linkUp);

  assert_mask_change_retrains_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(laneMask) |-> !linkUp);

  assert_rx_exclusive_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(rxOutValid && retryOut));

  assert_rx_has_cause_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rxOutValid || retryOut) |-> $past(rxValid));

endmodule

bind link_width_ctrl link_width_ctrl_checker #(.LANES(LANES)) u_checker (
  .clk(clk), .rstN(rstN), .widthMode(widthMode), .laneMask(laneMask),
  .clkLaneSel(clkLaneSel), .linkUp(linkUp), .txReady(txReady),
  .rxValid(rxValid), .rxOutValid(rxOutValid), .retryOut(retryOut)
);

// File: tb/link_width_ctrl_bench.sv
module link_width_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int LANES      = 20;
  localparam int DATA_W     = 32;
  localparam int TRAIN      = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              txValid = 1'b0;
  logic [DATA_W-1:0] txData = '0;
  logic              txReady;
  logic              linkTxValid;
  logic [DATA_W+7:0] linkTxFlit;
  logic              ackIn = 1'b0;
  logic              retryIn = 1'b0;
  logic              rxValid = 1'b0;
  logic [DATA_W+7:0] rxFlit = '0;
  logic              rxOutValid;
  logic [DATA_W-1:0] rxOutData;
  logic              retryOut;
  logic [LANES-1:0]  laneErr = '0;
  logic              clkFail = 1'b0;
  logic [7:0]        errThreshold = 8'd0;
  logic [1:0]        widthMode;
  logic [LANES-1:0]  laneMask;
  logic [1:0]        clkLaneSel;
  logic              linkUp;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  link_width_ctrl u_link_width_ctrl (
    .clk(clk), .rstN(rstN), .txValid(txValid), .txData(txData), .txReady(txReady),
    .linkTxValid(linkTxValid), .linkTxFlit(linkTxFlit), .ackIn(ackIn),
    .retryIn(retryIn), .rxValid(rxValid), .rxFlit(rxFlit),
    .rxOutValid(rxOutValid), .rxOutData(rxOutData), .retryOut(retryOut),
    .laneErr(laneErr), .clkFail(clkFail), .errThreshold(errThreshold),
    .widthMode(widthMode), .laneMask(laneMask), .clkLaneSel(clkLaneSel),
    .linkUp(linkUp)
  );

  function automatic logic [7:0] refCrc(input logic [DATA_W-1:0] d);
    logic [7:0] c = 8'h00;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      if (c[7] ^ d[i]) c = {c[6:0], 1'b0} ^ 8'h07;
      else             c = {c[6:0], 1'b0};
    end
    return c;
  endfunction

  function automatic logic [DATA_W+7:0] mkFlit(input logic [DATA_W-1:0] d);
    return {d, refCrc(d)};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitLink();
    for (int i = 0; i < 100 && !linkUp; i++) @(negedge clk);
  endtask

  task automatic resetDut();
    @(negedge clk);
    rstN = 1'b0; txValid = 0; ackIn = 0; retryIn = 0; rxValid = 0;
    laneErr = '0; clkFail = 0; errThreshold = 0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    waitLink();
  endtask

  task automatic sendFlit(input logic [DATA_W-1:0] d, input string req);
    txValid = 1'b1; txData = d;
    @(negedge clk);
    txValid = 1'b0;
    check({req, " tx valid"}, 64'(linkTxValid), 64'd1);
    check({req, " tx flit"}, 64'(linkTxFlit), 64'(mkFlit(d)));
  endtask

  task automatic ackN(input int n);
    for (int i = 0; i < n; i++) begin
      ackIn = 1'b1; @(negedge clk); ackIn = 1'b0;
    end
  endtask

  task automatic test_reset_R12();
    @(negedge clk);
    check("R12 width", 64'(widthMode), 64'd0);
    check("R12 mask", 64'(laneMask), 64'hFFFFF);
    check("R12 clksel", 64'(clkLaneSel), 64'd0);
    check("R12 linkUp low", 64'(linkUp), 64'd0);
    rstN = 1'b1;
    waitLink();
    check("R12 linkUp after training", 64'(linkUp), 64'd1);
    check("R12 txReady", 64'(txReady), 64'd1);
  endtask

  task automatic test_tx_R1();
    @(negedge clk);
    sendFlit(32'h0000_0000, "R1");
    sendFlit(32'hFFFF_FFFF, "R1");
    sendFlit(32'h1234_5678, "R1");
    @(negedge clk);
    check("R1 idle", 64'(linkTxValid), 64'd0);
    ackN(3);
  endtask

  task automatic rxOne(input logic [DATA_W+7:0] f, input logic good, input string req);
    rxValid = 1'b1; rxFlit = f;
    @(negedge clk);
    rxValid = 1'b0;
    check({req, " delivered"}, 64'(rxOutValid), 64'(good));
    check({req, " retry"}, 64'(retryOut), 64'(!good));
    if (good) check({req, " data"}, 64'(rxOutData), 64'(f[DATA_W+7:8]));
  endtask

  task automatic test_rx_R2();
    logic [DATA_W-1:0] d = 32'hCAFE_F00D;
    rxOne(mkFlit(d), 1'b1, "R2 good");
    rxOne(mkFlit(d) ^ 40'h00_0000_0100, 1'b0, "R2 one bit");
    rxOne(mkFlit(d) ^ 40'h80_0100_0001, 1'b0, "R2 three bit");
    rxOne(mkFlit(d) ^ 40'h00_00FF_0000, 1'b0, "R2 burst8");
    rxOne(mkFlit(32'h0BAD_BEEF), 1'b1, "R2 good again");
  endtask

  task automatic test_buffer_R3_R4();
    for (int i = 0; i < 8; i++) sendFlit(32'hA0 + 32'(i), "R3");
    check("R3 full blocks", 64'(txReady), 64'd0);
    ackN(1);
    check("R3 ack frees", 64'(txReady), 64'd1);
    retryIn = 1'b1;
    @(negedge clk);
    retryIn = 1'b0;
    check("R4 ready low in replay", 64'(txReady), 64'd0);
    for (int i = 1; i < 8; i++) begin
      @(negedge clk);
      check("R4 replay valid", 64'(linkTxValid), 64'd1);
      check("R4 replay order", 64'(linkTxFlit), 64'(mkFlit(32'hA0 + 32'(i))));
    end
    @(negedge clk);
    check("R4 replay ends", 64'(linkTxValid), 64'd0);
    ackN(7);
  endtask

  task automatic test_lane_degrade_R5_R6_R9();
    int lows;
    errThreshold = 8'd3;
    sendFlit(32'hD0, "R9");
    sendFlit(32'hD1, "R9");
    laneErr[7] = 1'b1;
    repeat (2) @(negedge clk);
    laneErr[7] = 1'b0;
    repeat (3) @(negedge clk);
    check("R5 below threshold", 64'(widthMode), 64'd0);
    laneErr[7] = 1'b1;
    @(negedge clk);
    laneErr[7] = 1'b0;
    @(negedge clk);
    check("R5 trip width", 64'(widthMode), 64'd1);
    check("R6 upper half kept", 64'(laneMask), 64'hFFC00);
    lows = 0;
    while (!linkUp && lows < 50) begin lows++; @(negedge clk); end
    check("R9 training length", 64'(lows), 64'(TRAIN));
    @(negedge clk);
    check("R9 replay first", 64'(linkTxFlit), 64'(mkFlit(32'hD0)));
    @(negedge clk);
    check("R9 replay second", 64'(linkTxFlit), 64'(mkFlit(32'hD1)));
    ackN(2);
  endtask

  task automatic test_inactive_R11();
    laneErr[9:0] = '1;
    repeat (5) @(negedge clk);
    laneErr = '0;
    repeat (2) @(negedge clk);
    check("R11 inactive ignored", 64'(widthMode), 64'd1);
  endtask

  task automatic test_crc_degrade_R7();
    for (int i = 0; i < 4; i++) begin
      rxValid = 1'b1; rxFlit = mkFlit(32'(i)) ^ 40'h1;
      @(negedge clk);
      check("R7 retry per bad", 64'(retryOut), 64'd1);
    end
    rxValid = 1'b0;
    check("R7 not yet", 64'(widthMode), 64'd1);
    @(negedge clk);
    check("R7 quarter", 64'(widthMode), 64'd2);
    check("R7 lower group of half", 64'(laneMask), 64'h07C00);
    waitLink();
  endtask

  task automatic test_clk_quarter_R10_R8();
    clkFail = 1'b1;
    @(negedge clk);
    check("R10 clk on lane 9", 64'(clkLaneSel), 64'd1);
    check("R10 width kept", 64'(widthMode), 64'd2);
    check("R9 clock retrains", 64'(linkUp), 64'd0);
    waitLink();
    clkFail = 1'b0;
    @(negedge clk);
    check("R10 clk sticky", 64'(clkLaneSel), 64'd1);
    laneErr[12] = 1'b1;
    repeat (6) @(negedge clk);
    laneErr = '0;
    repeat (2) @(negedge clk);
    check("R8 quarter final", 64'(widthMode), 64'd2);
    check("R8 mask final", 64'(laneMask), 64'h07C00);
  endtask

  task automatic test_clk_full_R10_R6();
    clkFail = 1'b1;
    @(negedge clk);
    clkFail = 1'b0;
    check("R10 full to half", 64'(widthMode), 64'd1);
    check("R10 lower half", 64'(laneMask), 64'h003FF);
    check("R10 clk on lane 10", 64'(clkLaneSel), 64'd2);
    waitLink();
    errThreshold = 8'd2;
    laneErr[10] = 1'b1;
    repeat (4) @(negedge clk);
    laneErr = '0;
    repeat (2) @(negedge clk);
    check("R11 clock lane ignored", 64'(widthMode), 64'd1);
    laneErr[1] = 1'b1;
    repeat (2) @(negedge clk);
    laneErr = '0;
    @(negedge clk);
    check("R6 quarter width", 64'(widthMode), 64'd2);
    check("R6 skips faulty group", 64'(laneMask), 64'h003E0);
  endtask

  task automatic test_threshold_off_R5();
    errThreshold = 8'd0;
    laneErr = '1;
    repeat (20) @(negedge clk);
    laneErr = '0;
    repeat (2) @(negedge clk);
    check("R5 threshold zero", 64'(widthMode), 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    test_reset_R12();
    test_tx_R1();
    test_rx_R2();
    test_buffer_R3_R4();
    test_lane_degrade_R5_R6_R9();
    test_inactive_R11();
    test_crc_degrade_R7();
    test_clk_quarter_R10_R8();
    resetDut();
    test_clk_full_R10_R6();
    resetDut();
    test_threshold_off_R5();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule